// File: doc/BRIEF.md
# Segmented I2C Master Message Sequencer

This block sits between a transfer controller and a byte-level I2C engine. It turns one master message into a series of hardware commands. The controller gives a start pulse together with the message length and direction. It also says whether another message follows in a combined transfer, and whether the message stands alone. The sequencer then splits the payload into segments of at most `SEG_MAX` bytes (four by default). It issues each segment as a one-cycle command to the engine and waits for that segment's completion report.

Segments inside a message are chained, so the engine holds the bus without a STOP between them. On the final segment, the sequencer asks for a repeated start when another message follows, and a STOP otherwise. The completion report carries the number of bytes actually moved. A short report ends the message with an error. A segment that never completes ends it with a timeout. When the bus may still be held, the sequencer sends an abort, waits for the bus to read free, and pulses an error-clear before it reports. A zero-length message is rejected unless it stands alone, in which case it is handed to the quick-command path.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of L bytes (L ≥ 1) produces ceil(L/SEG_MAX) segment commands. Segment k carries min(L − k·SEG_MAX, SEG_MAX) bytes.
- R2: The command count field `cmd_cnt_m1` holds the segment's byte count minus one. With the default SEG_MAX of 4 it is 2 bits wide, so 0 means 1 byte and 3 means 4 bytes. `cmd_rd` repeats the message direction on every segment.
- R3: `cmd_chain` is 1 on every segment except the last, and 0 on the last. A chained segment always carries SEG_MAX bytes.
- R4: On the last segment, `cmd_rstart` is 1 exactly when `msg_comb` was 1 at start. `cmd_chain` and `cmd_rstart` are never both 1.
- R5: For a write message, `wr_load` pulses in the cycle just before each `cmd_go`. For a read message, `wr_load` never pulses. At most one of `cmd_go`, `wr_load`, `abort_req`, `clr_err` and `quick_req` is high in any cycle.
- R6: If `seg_count` differs from the requested bytes, no further segment is issued and the result is 1 (short). `abort_req` pulses only when that segment was not the last or the message is combined.
- R7: If no `seg_done` arrives within TMO_CYC cycles of waiting, `abort_req` pulses TMO_CYC+1 cycles after that segment's `cmd_go`. The result is then 2 (timeout).
- R8: After any abort, the sequencer waits until `bus_free` is 1 before it pulses `clr_err`, and only then reports done.
- R9: For a zero-length message, `msg_alone` = 1 gives one `quick_req` pulse followed in the next cycle by done with result 4. `msg_alone` = 0 gives result 3 (bad length). Neither case issues a segment command.
- R10: A message whose segments all complete in full ends with result 0. `done` is a one-cycle pulse. After reset, every command and strobe output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a message (taken only when idle) |
| msg_len | input | LEN_W | Message length in bytes |
| msg_rd | input | 1 | 1 = read, 0 = write |
| msg_comb | input | 1 | Another message follows in a combined transfer |
| msg_alone | input | 1 | Message is the only one in its transfer |
| cmd_go | output | 1 | One-cycle segment command strobe |
| cmd_cnt_m1 | output | CW | Segment byte count minus one |
| cmd_rd | output | 1 | Segment direction |
| cmd_chain | output | 1 | Keep the bus, no STOP after this segment |
| cmd_rstart | output | 1 | Repeated start instead of STOP after this segment |
| wr_load | output | 1 | Load write data for the coming segment |
| seg_done | input | 1 | Segment completion strobe from the engine |
| seg_count | input | CNT_W | Bytes actually moved by the segment |
| abort_req | output | 1 | One-cycle abort command to the engine |
| bus_free | input | 1 | Bus-free status from the engine |
| clr_err | output | 1 | One-cycle error-clear strobe |
| quick_req | output | 1 | Hand a standalone zero-length message to the quick path |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 short, 2 timeout, 3 bad length, 4 quick |

## Verification
The checker assumes that the engine raises `seg_done` only while a segment is outstanding, and for one cycle per command. It also assumes that `start` arrives only while the block is idle. The bench's engine model keeps to both of these rules. It answers each command two cycles after `cmd_go`, or not at all for a stall case. It pulls `bus_free` low for three cycles after an abort, so the drain wait is actually exercised. Lengths, directions, combined flags and the failing segment are drawn at random around directed cases at the segment boundaries.

// File: rtl/i2c_chunk_seq_pkg.sv
// Shared types for the segmented I2C master sequencer.
// Assumes: result codes are fixed and visible to the controller above.
package i2c_chunk_seq_pkg;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_SHORT   = 3'd1,
        RES_TIMEOUT = 3'd2,
        RES_BADLEN  = 3'd3,
        RES_QUICK   = 3'd4
    } res_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_QUICK,
        ST_LOAD,
        ST_ISSUE,
        ST_WAIT,
        ST_ABORT,
        ST_DRAIN,
        ST_CLEAR
    } seq_state_t;

endpackage

// File: rtl/seg_planner.sv
// Derives the next segment's fields from the bytes still to move.
// Assumes: rem_bytes is nonzero whenever the fields are used.
module seg_planner #(
    parameter int LEN_W   = 8,
    parameter int SEG_MAX = 4,
    localparam int CW     = $clog2(SEG_MAX),
    localparam int CNT_W  = $clog2(SEG_MAX + 1)
) (
    input  logic [LEN_W-1:0] rem_bytes,
    input  logic             comb,
    output logic [CNT_W-1:0] seg_bytes,
    output logic [CW-1:0]    cnt_m1,
    output logic             chain,
    output logic             rstart
);
    localparam logic [LEN_W-1:0] SEG_L = LEN_W'(SEG_MAX);

    // Segment size, encoded count, chain and repeated-start choice.
    always_comb begin
        chain     = rem_bytes > SEG_L;
        seg_bytes = chain ? CNT_W'(SEG_MAX) : CNT_W'(rem_bytes);
        cnt_m1    = CW'(seg_bytes - CNT_W'(1));
        rstart    = !chain && comb;
    end
endmodule

// File: rtl/seg_watchdog.sv
// Counts cycles spent waiting for a segment and flags expiry.
// Assumes: arm pulses once per segment, before the wait begins.
module seg_watchdog #(
    parameter int TMO_CYC = 64,
    localparam int TW     = $clog2(TMO_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic expired
);
    logic [TW-1:0] cnt;

    // Restart on a new segment, advance while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (arm)    cnt <= '0;
        else if (run && !expired) cnt <= cnt + TW'(1);
    end

    assign expired = run && (cnt == TW'(TMO_CYC - 1));
endmodule

// File: rtl/i2c_chunk_seq.sv
// Splits one I2C master message into chained segments for a byte engine,
// checks each completion count and handles abort / bus-free / clear.
// Assumes: start only while idle; seg_done only while a segment is pending.
module i2c_chunk_seq
    import i2c_chunk_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int SEG_MAX = 4,
    parameter int TMO_CYC = 64,
    localparam int CW     = $clog2(SEG_MAX),
    localparam int CNT_W  = $clog2(SEG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             msg_rd,
    input  logic             msg_comb,
    input  logic             msg_alone,
    output logic             cmd_go,
    output logic [CW-1:0]    cmd_cnt_m1,
    output logic             cmd_rd,
    output logic             cmd_chain,
    output logic             cmd_rstart,
    output logic             wr_load,
    input  logic             seg_done,
    input  logic [CNT_W-1:0] seg_count,
    output logic             abort_req,
    input  logic             bus_free,
    output logic             clr_err,
    output logic             quick_req,
    output logic             done,
    output logic [2:0]       result
);
    seq_state_t       state;
    logic [LEN_W-1:0] rem;
    logic             rd_q, comb_q;
    res_t             code_q;
    logic [CNT_W-1:0] seg_bytes;
    logic             chain, rstart, expired;

    seg_planner #(.LEN_W(LEN_W), .SEG_MAX(SEG_MAX)) u_plan (
        .rem_bytes (rem),
        .comb      (comb_q),
        .seg_bytes (seg_bytes),
        .cnt_m1    (cmd_cnt_m1),
        .chain     (chain),
        .rstart    (rstart)
    );

    seg_watchdog #(.TMO_CYC(TMO_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (cmd_go),
        .run     (state == ST_WAIT),
        .expired (expired)
    );

    // Strobes and command fields decoded from the current state.
    always_comb begin
        cmd_go     = state == ST_ISSUE;
        wr_load    = state == ST_LOAD;
        abort_req  = state == ST_ABORT;
        clr_err    = state == ST_CLEAR;
        quick_req  = state == ST_QUICK;
        cmd_rd     = rd_q;
        cmd_chain  = cmd_go && chain;
        cmd_rstart = cmd_go && rstart;
    end

    // Message sequencing, completion checking and error recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rem    <= '0;
            rd_q   <= 1'b0;
            comb_q <= 1'b0;
            code_q <= RES_OK;
            done   <= 1'b0;
            result <= 3'd0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (msg_len == '0) begin
                        if (msg_alone) state <= ST_QUICK;
                        else begin
                            done   <= 1'b1;
                            result <= RES_BADLEN;
                        end
                    end else begin
                        rem    <= msg_len;
                        rd_q   <= msg_rd;
                        comb_q <= msg_comb;
                        state  <= msg_rd ? ST_ISSUE : ST_LOAD;
                    end
                end
                ST_QUICK: begin
                    state  <= ST_IDLE;
                    done   <= 1'b1;
                    result <= RES_QUICK;
                end
                ST_LOAD:  state <= ST_ISSUE;
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (seg_done) begin
                        if (seg_count != seg_bytes) begin
                            code_q <= RES_SHORT;
                            if (chain || comb_q) state <= ST_ABORT;
                            else begin
                                state  <= ST_IDLE;
                                done   <= 1'b1;
                                result <= RES_SHORT;
                            end
                        end else if (!chain) begin
                            state  <= ST_IDLE;
                            done   <= 1'b1;
                            result <= RES_OK;
                        end else begin
                            rem   <= rem - LEN_W'(seg_bytes);
                            state <= rd_q ? ST_ISSUE : ST_LOAD;
                        end
                    end else if (expired) begin
                        code_q <= RES_TIMEOUT;
                        state  <= ST_ABORT;
                    end
                end
                ST_ABORT: state <= ST_DRAIN;
                ST_DRAIN: if (bus_free) state <= ST_CLEAR;
                ST_CLEAR: begin
                    state  <= ST_IDLE;
                    done   <= 1'b1;
                    result <= code_q;
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_chunk_seq_chk.sv
// Protocol checker for the segmented sequencer, bound to its top module.
// Assumes: synchronous active-low reset; only ports are observed.
module i2c_chunk_seq_chk #(
    parameter int SEG_MAX = 4,
    localparam int CW     = $clog2(SEG_MAX)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_go,
    input logic [CW-1:0] cmd_cnt_m1,
    input logic          cmd_chain,
    input logic          cmd_rstart,
    input logic          wr_load,
    input logic          abort_req,
    input logic          bus_free,
    input logic          clr_err,
    input logic          quick_req,
    input logic          done,
    input logic [2:0]    result
);
    assert_one_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_go, wr_load, abort_req, clr_err, quick_req}));

    assert_load_then_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> cmd_go);

    assert_chain_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_chain) |-> (cmd_cnt_m1 == CW'(SEG_MAX - 1)));

    assert_chain_rstart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_chain && cmd_rstart));

    assert_clear_busfree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |-> bus_free);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quick_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        quick_req |=> (done && result == 3'd4));
endmodule

bind i2c_chunk_seq i2c_chunk_seq_chk #(.SEG_MAX(SEG_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_go     (cmd_go),
    .cmd_cnt_m1 (cmd_cnt_m1),
    .cmd_chain  (cmd_chain),
    .cmd_rstart (cmd_rstart),
    .wr_load    (wr_load),
    .abort_req  (abort_req),
    .bus_free   (bus_free),
    .clr_err    (clr_err),
    .quick_req  (quick_req),
    .done       (done),
    .result     (result)
);

// File: tb/tb_i2c_chunk_seq.sv
// Bench: models the byte engine, drives random and directed messages.
module tb_i2c_chunk_seq;
    localparam int LEN_W   = 8;
    localparam int SEG_MAX = 4;
    localparam int TMO_CYC = 64;
    localparam int CW      = $clog2(SEG_MAX);
    localparam int CNT_W   = $clog2(SEG_MAX + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, msg_rd = 1'b0, msg_comb = 1'b0, msg_alone = 1'b0;
    logic [LEN_W-1:0] msg_len = '0;
    logic cmd_go, cmd_rd, cmd_chain, cmd_rstart, wr_load;
    logic [CW-1:0] cmd_cnt_m1;
    logic seg_done = 1'b0;
    logic [CNT_W-1:0] seg_count = '0;
    logic abort_req, bus_free = 1'b1, clr_err, quick_req, done;
    logic [2:0] result;

    int vecs = 0, fails = 0;

    always #5 clk = ~clk;

    i2c_chunk_seq #(.LEN_W(LEN_W), .SEG_MAX(SEG_MAX), .TMO_CYC(TMO_CYC)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int seg_total(input int len);
        return (len + SEG_MAX - 1) / SEG_MAX;
    endfunction

    function automatic int seg_size(input int len, input int k);
        int r = len - k * SEG_MAX;
        return (r > SEG_MAX) ? SEG_MAX : r;
    endfunction

    // One message; short_at / stall_at pick a failing segment, -1 for none.
    task automatic run_msg(input int len, input bit rd, input bit comb,
                           input bit alone, input int short_at, input int stall_at);
        int segs = seg_total(len);
        int k = 0, resp_cd = 0, busy_cd = 0, cyc = 0, go_cyc = 0, cur = 0;
        int aborts = 0, clrs = 0, quicks = 0, exp_k, exp_res, exp_ab;
        bit load_seen = 0, finished = 0;
        exp_k = segs; exp_res = 0; exp_ab = 0;
        if (len == 0) begin exp_k = 0; exp_res = alone ? 4 : 3; end
        else if (stall_at >= 0) begin exp_k = stall_at + 1; exp_res = 2; exp_ab = 1; end
        else if (short_at >= 0) begin
            exp_k = short_at + 1; exp_res = 1;
            exp_ab = (short_at < segs - 1 || comb) ? 1 : 0;
        end
        @(negedge clk);
        msg_len = LEN_W'(len); msg_rd = rd; msg_comb = comb; msg_alone = alone;
        start = 1'b1;
        while (!finished) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (seg_done) seg_done = 1'b0;
            if (wr_load) load_seen = 1;
            if (quick_req) quicks++;
            if (cmd_go) begin
                cur = seg_size(len, k);
                chk(int'(cmd_cnt_m1) == cur - 1, "R1/R2 count field", int'(cmd_cnt_m1), cur - 1);
                chk(cmd_rd == rd, "R2 direction", int'(cmd_rd), int'(rd));
                chk(cmd_chain == (k < segs - 1), "R3 chain", int'(cmd_chain), int'(k < segs - 1));
                chk(cmd_rstart == (k == segs - 1 && comb), "R4 rstart",
                    int'(cmd_rstart), int'(k == segs - 1 && comb));
                chk(load_seen == !rd, "R5 write load", int'(load_seen), int'(!rd));
                load_seen = 0;
                go_cyc = cyc;
                if (k != stall_at) resp_cd = 2;
                k++;
            end
            if (resp_cd > 0) begin
                resp_cd--;
                if (resp_cd == 0) begin
                    seg_done  = 1'b1;
                    seg_count = CNT_W'((k - 1 == short_at) ? cur - 1 : cur);
                end
            end
            if (abort_req) begin
                aborts++;
                if (stall_at >= 0)
                    chk(cyc - go_cyc == TMO_CYC + 1, "R7 timeout delay", cyc - go_cyc, TMO_CYC + 1);
                bus_free = 1'b0; busy_cd = 3;
            end else if (busy_cd > 0) begin
                busy_cd--;
                if (busy_cd == 0) bus_free = 1'b1;
            end
            if (clr_err) clrs++;
            if (done) begin
                finished = 1;
                chk(int'(result) == exp_res, "R6/R7/R9/R10 result", int'(result), exp_res);
                chk(k == exp_k, "R1/R6/R9 segments issued", k, exp_k);
                chk(aborts == exp_ab, "R6/R7 aborts", aborts, exp_ab);
                chk(clrs == exp_ab, "R8 clears", clrs, exp_ab);
                chk(quicks == ((len == 0 && alone) ? 1 : 0), "R9 quick", quicks,
                    (len == 0 && alone) ? 1 : 0);
            end
            if (cyc > 3000) begin
                chk(0, "R10 message never completed", cyc, 0);
                finished = 1;
            end
        end
        @(negedge clk);
        chk(!done, "R10 done pulse width", int'(done), 0);
        seg_done = 1'b0; bus_free = 1'b1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        int len, segs, sa, st;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk({cmd_go, wr_load, abort_req, clr_err, quick_req, done} == 6'b0,
            "R10 reset outputs", int'({cmd_go, wr_load, abort_req, clr_err, quick_req, done}), 0);
        rst_n = 1'b1;
        // Directed corners.
        run_msg(4, 1'b0, 1'b0, 1'b1, -1, -1);   // R1 exactly one full segment
        run_msg(5, 1'b1, 1'b1, 1'b0, -1, -1);   // R3 R4 chained then rstart
        run_msg(1, 1'b0, 1'b0, 1'b1, -1, -1);
        run_msg(0, 1'b0, 1'b0, 1'b1, -1, -1);   // R9 quick
        run_msg(0, 1'b1, 1'b1, 1'b0, -1, -1);   // R9 bad length
        run_msg(8, 1'b1, 1'b0, 1'b1, 1, -1);    // R6 short on last, no abort
        run_msg(8, 1'b0, 1'b1, 1'b0, 1, -1);    // R6 short on last, combined
        run_msg(9, 1'b0, 1'b0, 1'b1, 0, -1);    // R6 short mid-message
        run_msg(6, 1'b1, 1'b0, 1'b1, -1, 1);    // R7 R8 timeout
        // Constrained random.
        for (int i = 0; i < 40; i++) begin
            len  = 1 + int'($urandom % 20);
            segs = seg_total(len);
            sa = -1; st = -1;
            if ($urandom % 4 == 0)      sa = int'($urandom % segs);
            else if ($urandom % 8 == 0) st = int'($urandom % segs);
            run_msg(len, 1'($urandom), 1'($urandom), 1'($urandom), sa, st);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule